// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one direct-memory-access channel. Software programs it through a small word-addressed register port. It holds a peripheral-side address, a memory-side address, an item count and a control word. Once enabled, the channel moves one data item at a time. Each item is a read beat from the source side followed by a write beat to the destination side, on a single-beat master bus.

In peripheral-paced mode, each item waits for a request from the peripheral. The channel answers with a one-cycle acknowledge when the item's write beat completes. In memory-to-memory mode, items run back to back as soon as the enable bit is set, and the request line is ignored. The channel raises half-transfer, transfer-complete and transfer-error flags, which are combined with their enables into one interrupt line. A bus error stops the channel by clearing its enable bit. Circular mode reloads the count and both addresses after the last item.

The master bus is a valid/ready handshake. The channel raises `m_valid` and then holds the address, direction, size and write data unchanged until the cycle in which `m_ready` is high; the beat completes at that clock edge. `m_rdata` and `m_err` are sampled in that same cycle, so a slave applies back-pressure simply by holding `m_ready` low. The peripheral holds `periph_req` high until it sees `periph_ack`, and drops it at that same edge if it has no further item.

Top module: `dma_channel`

## Requirements
- R1: Registers are selected by `cfg_addr`: 0 control, 1 peripheral address, 2 memory address, 3 count, 4 status flags. Reads return the current values, with count giving the remaining items and the address registers giving the current addresses. After reset every register reads 0.
- R2: A write to registers 1, 2 or 3 is ignored while the enable bit is 1 or an item is still in flight. Otherwise the write loads both the programmed value and the current value.
- R3: The control bits are: 0 enable, 1 direction (0 = peripheral to memory, 1 = memory to peripheral), 2 circular, 3 peripheral increment, 4 memory increment, 6:5 peripheral size, 8:7 memory size, 9 half-transfer interrupt enable, 10 complete interrupt enable, 11 error interrupt enable, 13:12 priority (stored and read back only), 14 memory-to-memory. Control writes are accepted at any time.
- R4: In peripheral-paced mode, an item starts only while `periph_req` is high. `periph_ack` is high for exactly the cycle in which that item's write beat completes without error, and there is one acknowledge per item.
- R5: In memory-to-memory mode, items start with no request, and `periph_ack` stays low.
- R6: Each item is a read beat (`m_write`=0) at the source address, then a write beat (`m_write`=1) at the destination address. `m_size` is the size field of the side being accessed. The write data is the read data masked to the destination size.
- R7: The size encoding is 00 = 1 byte, 01 = 2 bytes, 10 or 11 = 4 bytes. After each completed item, a side with its increment bit set advances by its own byte size; a side without it keeps its address.
- R8: The count drops by one after each completed item. With circular mode off, no further beats are issued once the count reaches 0. Enabling the channel with a count of 0 issues no beats.
- R9: Status bit 0 (half) sets when an item leaves the remaining count equal to the programmed count divided by 2, rounded down. Status bit 1 (complete) sets when an item leaves the count at 0. Both flags stay set until software writes 1 to that bit of register 4.
- R10: In circular mode, the item that brings the count to 0 reloads the count and both addresses from their programmed values, and transfers continue.
- R11: A beat that ends with `m_err` high sets status bit 2 and clears the enable bit. That item is not counted, and no further beats are issued.
- R12: `irq` is high exactly when some status flag is set together with its interrupt enable bit.
- R13: While `m_valid` is high and `m_ready` is low, the next cycle keeps `m_valid` high with `m_addr`, `m_write`, `m_size` and `m_wdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| periph_req | input | 1 | Peripheral request for one item |
| periph_ack | output | 1 | One-cycle acknowledge of a finished item |
| m_valid | output | 1 | Master beat valid |
| m_ready | input | 1 | Slave accepts the beat |
| m_write | output | 1 | Beat is a write |
| m_addr | output | 32 | Beat byte address |
| m_size | output | 2 | Beat size code |
| m_wdata | output | 32 | Write data |
| m_rdata | input | 32 | Read data, valid with `m_ready` |
| m_err | input | 1 | Beat error, valid with `m_ready` |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest situation to reach from the ports is a bus error that lands on the write beat of an item in the middle of a run. At that point the item has already been read, but it must not be counted or acknowledged, and the channel must then go silent. The bench keeps a free-running count of completed beats and arms the error for a specific future beat index, so the fault hits exactly the second item's write. The circular wrap combined with the half flag firing twice is reached by issuing more peripheral requests than the programmed count. A slave that toggles `m_ready` exercises the hold rule under back-pressure.

// File: rtl/dma_channel_pkg.sv
package dma_channel_pkg;

  localparam int DATA_W = 32;
  localparam int CTRL_W = 15;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_PADDR = 3'd1;
  localparam logic [2:0] RA_MADDR = 3'd2;
  localparam logic [2:0] RA_CNT   = 3'd3;
  localparam logic [2:0] RA_STAT  = 3'd4;

  typedef struct packed {
    logic       m2m;
    logic [1:0] prio;
    logic       te_ie;
    logic       tc_ie;
    logic       ht_ie;
    logic [1:0] msize;
    logic [1:0] psize;
    logic       minc;
    logic       pinc;
    logic       circ;
    logic       dir;
    logic       en;
  } ctrl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} xfer_st_t;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'b00:   size_bytes = 3'd1;
      2'b01:   size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'b00:   size_mask = 32'h0000_00FF;
      2'b01:   size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/dma_channel_regs.sv
module dma_channel_regs
  import dma_channel_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [2:0]                 cfg_addr,
  input  logic [DATA_W-1:0]          cfg_wdata,
  output logic [DATA_W-1:0]          cfg_rdata,
  input  logic [ADDR_W-1:0]          cur_paddr,
  input  logic [ADDR_W-1:0]          cur_maddr,
  input  logic [CNT_W-1:0]           cur_cnt,
  input  logic                       busy,
  input  logic                       err_evt,
  input  logic                       ht_evt,
  input  logic                       tc_evt,
  output ctrl_t                      ctrl,
  output logic                       ld_paddr,
  output logic                       ld_maddr,
  output logic                       ld_cnt,
  output logic                       irq
);

  localparam int FLAG_W = 3;

  ctrl_t             ctrl_q;
  logic [FLAG_W-1:0] flags_q;
  logic [FLAG_W-1:0] flag_set;
  logic [FLAG_W-1:0] flag_clr;
  logic              ld_ok;

  assign ld_ok    = cfg_we && !ctrl_q.en && !busy;
  assign ld_paddr = ld_ok && (cfg_addr == RA_PADDR);
  assign ld_maddr = ld_ok && (cfg_addr == RA_MADDR);
  assign ld_cnt   = ld_ok && (cfg_addr == RA_CNT);

  assign flag_set = {err_evt, tc_evt, ht_evt};
  assign flag_clr = (cfg_we && cfg_addr == RA_STAT) ? cfg_wdata[FLAG_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      flags_q <= '0;
    end else begin
      if (cfg_we && cfg_addr == RA_CTRL) ctrl_q <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
      if (err_evt) ctrl_q.en <= 1'b0;
      flags_q <= (flags_q & ~flag_clr) | flag_set;
    end
  end

  always_comb begin
    case (cfg_addr)
      RA_CTRL:  cfg_rdata = DATA_W'(ctrl_q);
      RA_PADDR: cfg_rdata = DATA_W'(cur_paddr);
      RA_MADDR: cfg_rdata = DATA_W'(cur_maddr);
      RA_CNT:   cfg_rdata = DATA_W'(cur_cnt);
      RA_STAT:  cfg_rdata = DATA_W'(flags_q);
      default:  cfg_rdata = '0;
    endcase
  end

  assign ctrl = ctrl_q;
  assign irq  = |(flags_q & {ctrl_q.te_ie, ctrl_q.tc_ie, ctrl_q.ht_ie});

  a_r11_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> !ctrl_q.en && flags_q[2]);

  a_r9_half_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[0] && !(cfg_we && cfg_addr == RA_STAT && cfg_wdata[0]) |=> flags_q[0]);

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[1] && !(cfg_we && cfg_addr == RA_STAT && cfg_wdata[1]) |=> flags_q[1]);

endmodule

// File: rtl/dma_channel_ptr.sv
module dma_channel_ptr
  import dma_channel_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_paddr,
  input  logic              ld_maddr,
  input  logic              ld_cnt,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_cnt,
  input  logic              step,
  input  logic              circ,
  input  logic              pinc,
  input  logic              minc,
  input  logic [1:0]        psize,
  input  logic [1:0]        msize,
  output logic [ADDR_W-1:0] paddr,
  output logic [ADDR_W-1:0] maddr,
  output logic [CNT_W-1:0]  cnt,
  output logic              ht_evt,
  output logic              tc_evt
);

  localparam int SIDES = 2;

  logic [CNT_W-1:0]  cnt_q, cnt_base, cnt_next;
  logic              wrap;
  logic [SIDES-1:0]  side_ld, side_inc;
  logic [1:0]        side_sz [SIDES];
  logic [ADDR_W-1:0] cur_q   [SIDES];
  logic [ADDR_W-1:0] base_q  [SIDES];

  assign cnt_next = cnt_q - 1'b1;
  assign wrap     = circ && (cnt_next == '0);
  assign ht_evt   = step && (cnt_next == (cnt_base >> 1));
  assign tc_evt   = step && (cnt_next == '0);

  assign side_ld    = {ld_maddr, ld_paddr};
  assign side_inc   = {minc, pinc};
  assign side_sz[0] = psize;
  assign side_sz[1] = msize;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_q[s]  <= '0;
        base_q[s] <= '0;
      end else if (side_ld[s]) begin
        cur_q[s]  <= wr_addr;
        base_q[s] <= wr_addr;
      end else if (step) begin
        if (wrap)             cur_q[s] <= base_q[s];
        else if (side_inc[s]) cur_q[s] <= cur_q[s] + ADDR_W'(size_bytes(side_sz[s]));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      cnt_base <= '0;
    end else if (ld_cnt) begin
      cnt_q    <= wr_cnt;
      cnt_base <= wr_cnt;
    end else if (step) begin
      cnt_q <= wrap ? cnt_base : cnt_next;
    end
  end

  assign paddr = cur_q[0];
  assign maddr = cur_q[1];
  assign cnt   = cnt_q;

  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    step && !circ |=> cnt_q == $past(cnt_q) - 1'b1);

  a_r10_reload: assert property (@(posedge clk) disable iff (!rst_n)
    step && circ && cnt_q == 1 |=> cnt_q == cnt_base && paddr == base_q[0] && maddr == base_q[1]);

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !ld_cnt |=> $stable(cnt_q));

endmodule

// File: rtl/dma_channel_engine.sv
module dma_channel_engine
  import dma_channel_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              m2m,
  input  logic              dir,
  input  logic [1:0]        psize,
  input  logic [1:0]        msize,
  input  logic              cnt_nz,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [ADDR_W-1:0] maddr,
  input  logic              periph_req,
  output logic              periph_ack,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              m_write,
  output logic [ADDR_W-1:0] m_addr,
  output logic [1:0]        m_size,
  output logic [DATA_W-1:0] m_wdata,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic              m_err,
  output logic              step,
  output logic              err_evt,
  output logic              busy
);

  xfer_st_t          st_q;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic [1:0]        src_sz, dst_sz;
  logic              start, beat_done;

  assign src_addr = dir ? maddr : paddr;
  assign dst_addr = dir ? paddr : maddr;
  assign src_sz   = dir ? msize : psize;
  assign dst_sz   = dir ? psize : msize;

  assign start     = (st_q == ST_IDLE) && en && cnt_nz && (m2m || periph_req);
  assign beat_done = m_valid && m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      data_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) st_q <= ST_RD;
        ST_RD: if (beat_done) begin
          if (m_err) st_q <= ST_IDLE;
          else begin
            data_q <= m_rdata & size_mask(dst_sz);
            st_q   <= ST_WR;
          end
        end
        ST_WR:   if (beat_done) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign m_valid    = (st_q != ST_IDLE);
  assign m_write    = (st_q == ST_WR);
  assign m_addr     = m_write ? dst_addr : src_addr;
  assign m_size     = m_write ? dst_sz : src_sz;
  assign m_wdata    = m_write ? data_q : '0;
  assign step       = m_write && beat_done && !m_err;
  assign err_evt    = beat_done && m_err;
  assign periph_ack = step && !m2m;
  assign busy       = m_valid;

  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_addr) && $stable(m_write)
                            && $stable(m_size) && $stable(m_wdata));

  a_r4_req_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(m2m) || $past(periph_req));

  a_r4_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    periph_ack |=> !periph_ack);

  a_r11_quiet_after_err: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> !m_valid);

endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_channel_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              periph_req,
  output logic              periph_ack,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              m_write,
  output logic [ADDR_W-1:0] m_addr,
  output logic [1:0]        m_size,
  output logic [31:0]       m_wdata,
  input  logic [31:0]       m_rdata,
  input  logic              m_err,
  output logic              irq
);

  ctrl_t             ctrl;
  logic              ld_paddr, ld_maddr, ld_cnt;
  logic              step, err_evt, busy, ht_evt, tc_evt;
  logic [ADDR_W-1:0] paddr, maddr;
  logic [CNT_W-1:0]  cnt;

  dma_channel_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cur_paddr(paddr), .cur_maddr(maddr), .cur_cnt(cnt), .busy(busy),
    .err_evt(err_evt), .ht_evt(ht_evt), .tc_evt(tc_evt), .ctrl(ctrl),
    .ld_paddr(ld_paddr), .ld_maddr(ld_maddr), .ld_cnt(ld_cnt), .irq(irq)
  );

  dma_channel_ptr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .ld_paddr(ld_paddr), .ld_maddr(ld_maddr),
    .ld_cnt(ld_cnt), .wr_addr(cfg_wdata[ADDR_W-1:0]), .wr_cnt(cfg_wdata[CNT_W-1:0]),
    .step(step), .circ(ctrl.circ), .pinc(ctrl.pinc), .minc(ctrl.minc),
    .psize(ctrl.psize), .msize(ctrl.msize), .paddr(paddr), .maddr(maddr),
    .cnt(cnt), .ht_evt(ht_evt), .tc_evt(tc_evt)
  );

  dma_channel_engine #(.ADDR_W(ADDR_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .en(ctrl.en), .m2m(ctrl.m2m), .dir(ctrl.dir),
    .psize(ctrl.psize), .msize(ctrl.msize), .cnt_nz(cnt != '0),
    .paddr(paddr), .maddr(maddr), .periph_req(periph_req), .periph_ack(periph_ack),
    .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write), .m_addr(m_addr),
    .m_size(m_size), .m_wdata(m_wdata), .m_rdata(m_rdata), .m_err(m_err),
    .step(step), .err_evt(err_evt), .busy(busy)
  );

endmodule

// File: tb/dma_channel_tb.sv
module dma_channel_tb;

  localparam int B_EN = 0, B_DIR = 1, B_CIRC = 2, B_PINC = 3, B_MINC = 4;
  localparam int B_PSZ = 5, B_MSZ = 7, B_HTIE = 9, B_TCIE = 10, B_TEIE = 11, B_M2M = 14;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        periph_req, periph_ack;
  logic        m_valid, m_ready, m_write, m_err, irq;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic [1:0]  m_size;

  int n_vec = 0, n_bad = 0;
  int req_issued = 0, req_acked = 0, beat_idx = 0;
  int rd_idx = 0, wr_idx = 0, err_at = -1;
  bit ready_toggle = 1'b0;
  logic [31:0] g_src, g_dst;
  logic [1:0]  g_ssz, g_dsz;
  bit          g_sinc, g_dinc;
  int          g_n = 1;
  bit          prev_stall = 1'b0;
  logic [31:0] prev_addr;

  always #10 clk = ~clk;

  dma_channel u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .periph_req(periph_req),
    .periph_ack(periph_ack), .m_valid(m_valid), .m_ready(m_ready),
    .m_write(m_write), .m_addr(m_addr), .m_size(m_size), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .m_err(m_err), .irq(irq)
  );

  function automatic logic [31:0] mdl(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[15:0] + 16'h1357};
  endfunction
  function automatic int nbytes(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
  endfunction
  function automatic logic [31:0] msk(input logic [1:0] s);
    return (s == 2'b00) ? 32'hFF : (s == 2'b01) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  assign periph_req = (req_issued != req_acked);
  assign m_rdata    = mdl(m_addr);
  assign m_err      = (err_at >= 0) && m_valid && (beat_idx == err_at);

  always @(posedge clk) begin
    m_ready <= ready_toggle ? ~m_ready : 1'b1;
    if (periph_ack) req_acked <= req_acked + 1;
    if (m_valid && m_ready) beat_idx <= beat_idx + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // beat monitor: R6, R7, R13
  always @(negedge clk) begin
    if (ready_toggle && prev_stall)
      chk(m_valid && m_addr == prev_addr, "R13 beat held under stall", m_addr, prev_addr);
    prev_stall = m_valid && !m_ready;
    prev_addr  = m_addr;
    if (m_valid && m_ready && !m_err) begin
      if (!m_write) begin
        logic [31:0] ea;
        ea = g_src + (g_sinc ? 32'((rd_idx % g_n) * nbytes(g_ssz)) : 32'd0);
        chk(m_addr == ea, "R7 source address", m_addr, ea);
        chk(m_size == g_ssz, "R6 source size", 32'(m_size), 32'(g_ssz));
        rd_idx++;
      end else begin
        logic [31:0] ea, sa, ed;
        ea = g_dst + (g_dinc ? 32'((wr_idx % g_n) * nbytes(g_dsz)) : 32'd0);
        sa = g_src + (g_sinc ? 32'((wr_idx % g_n) * nbytes(g_ssz)) : 32'd0);
        ed = mdl(sa) & msk(g_dsz);
        chk(m_addr == ea, "R7 destination address", m_addr, ea);
        chk(m_wdata == ed, "R6 write data", m_wdata, ed);
        chk(m_size == g_dsz, "R6 destination size", 32'(m_size), 32'(g_dsz));
        wr_idx++;
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask
  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; #1 d = cfg_rdata;
  endtask
  task automatic setup(input logic [31:0] src, dst, input logic [1:0] ssz, dsz,
                       input bit sinc, dinc, input int n);
    g_src = src; g_dst = dst; g_ssz = ssz; g_dsz = dsz;
    g_sinc = sinc; g_dinc = dinc; g_n = n; rd_idx = 0; wr_idx = 0;
  endtask
  task automatic reqs(input int k);
    @(negedge clk); req_issued += k;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); chk(v == 0, "R1 register reads zero after reset", v, 0);
    end
    chk(!irq && !m_valid, "R1 outputs idle after reset", {irq, m_valid}, 0);
  endtask

  task automatic t_m2m;
    logic [31:0] v;
    setup(32'h100, 32'h2000, 2'b10, 2'b10, 1, 1, 4);
    wr(1, 32'h100); wr(2, 32'h2000); wr(3, 4);
    rd(1, v); chk(v == 32'h100, "R1 peripheral address readback", v, 32'h100);
    rd(3, v); chk(v == 4, "R1 count readback", v, 4);
    wr(0, (1 << B_EN) | (1 << B_M2M) | (1 << B_PINC) | (1 << B_MINC) | (2 << B_PSZ) | (2 << B_MSZ) | (1 << B_TCIE));
    repeat (40) @(negedge clk);
    chk(wr_idx == 4, "R5 memory-to-memory runs without request", wr_idx, 4);
    chk(req_acked == 0, "R5 no acknowledge in m2m mode", req_acked, 0);
    rd(3, v); chk(v == 0, "R8 count reaches zero", v, 0);
    rd(4, v); chk(v == 3, "R9 half and complete set", v, 3);
    chk(irq == 1, "R12 irq from complete flag", irq, 1);
    wr(4, 3); rd(4, v); chk(v == 0, "R9 flags cleared by writing one", v, 0);
    chk(irq == 0, "R12 irq drops after clear", irq, 0);
    rd(0, v); chk(v[0] == 1, "R3 enable stays set after normal finish", v, 1);
    wr(0, 0);
  endtask

  task automatic t_periph;
    logic [31:0] v;
    setup(32'h3000, 32'h40, 2'b00, 2'b01, 1, 0, 6);
    wr(1, 32'h40); wr(2, 32'h3000); wr(3, 6);
    wr(0, (1 << B_EN) | (1 << B_DIR) | (1 << B_MINC) | (1 << B_PSZ) | (1 << B_HTIE));
    repeat (20) @(negedge clk);
    chk(wr_idx == 0 && !m_valid, "R4 no beat without request", wr_idx, 0);
    reqs(3); repeat (30) @(negedge clk);
    chk(wr_idx == 3, "R4 one item per request", wr_idx, 3);
    chk(req_acked == 3, "R4 one acknowledge per item", req_acked, 3);
    rd(3, v); chk(v == 3, "R8 count after three items", v, 3);
    rd(4, v); chk(v == 1, "R9 half flag alone at midpoint", v, 1);
    chk(irq == 1, "R12 irq from half flag", irq, 1);
    rd(1, v); chk(v == 32'h40, "R7 fixed peripheral address", v, 32'h40);
    rd(2, v); chk(v == 32'h3003, "R7 memory address stepped by bytes", v, 32'h3003);
    reqs(3); repeat (30) @(negedge clk);
    rd(4, v); chk(v == 3, "R9 complete after last item", v, 3);
    reqs(1); repeat (20) @(negedge clk);
    chk(wr_idx == 6, "R8 no beats once count is zero", wr_idx, 6);
    wr(0, 0); @(negedge clk); req_issued = req_acked; wr(4, 7);
  endtask

  task automatic t_circ;
    logic [31:0] v;
    setup(32'h80, 32'h4000, 2'b01, 2'b10, 1, 1, 3);
    wr(1, 32'h80); wr(2, 32'h4000); wr(3, 3);
    wr(0, (1 << B_EN) | (1 << B_CIRC) | (1 << B_PINC) | (1 << B_MINC) | (1 << B_PSZ) | (2 << B_MSZ));
    reqs(5); repeat (60) @(negedge clk);
    chk(wr_idx == 5, "R10 circular keeps running", wr_idx, 5);
    rd(3, v); chk(v == 1, "R10 count reloaded", v, 1);
    rd(1, v); chk(v == 32'h84, "R10 peripheral address wrapped", v, 32'h84);
    rd(2, v); chk(v == 32'h4008, "R10 memory address wrapped", v, 32'h4008);
    rd(4, v); chk(v == 3, "R9 flags in circular run", v, 3);
    chk(irq == 0, "R12 irq masked with enables off", irq, 0);
    wr(1, 32'hDEAD00); wr(3, 9);
    rd(1, v); chk(v == 32'h84, "R2 address write ignored while enabled", v, 32'h84);
    rd(3, v); chk(v == 1, "R2 count write ignored while enabled", v, 1);
    wr(0, 0); wr(4, 7);
    wr(3, 2); rd(3, v); chk(v == 2, "R2 count write accepted when disabled", v, 2);
  endtask

  task automatic t_err;
    logic [31:0] v;
    int b0;
    setup(32'h100, 32'h2000, 2'b10, 2'b10, 1, 1, 4);
    wr(1, 32'h100); wr(2, 32'h2000); wr(3, 4);
    @(negedge clk); b0 = beat_idx; err_at = b0 + 3;
    wr(0, (1 << B_EN) | (1 << B_M2M) | (1 << B_PINC) | (1 << B_MINC) | (2 << B_PSZ) | (2 << B_MSZ) | (1 << B_TEIE));
    repeat (40) @(negedge clk);
    chk(beat_idx - b0 == 4, "R11 no beats after error", beat_idx - b0, 4);
    chk(wr_idx == 1, "R11 one item completed", wr_idx, 1);
    rd(3, v); chk(v == 3, "R11 failed item not counted", v, 3);
    rd(0, v); chk(v[0] == 0, "R11 enable cleared by hardware", v[0], 0);
    rd(4, v); chk(v == 4, "R11 error flag set", v, 4);
    chk(irq == 1, "R12 irq from error flag", irq, 1);
    err_at = -1; wr(4, 7);
  endtask

  task automatic t_backpressure;
    setup(32'h5000, 32'h200, 2'b01, 2'b00, 1, 0, 5);
    ready_toggle = 1'b1;
    wr(1, 32'h200); wr(2, 32'h5000); wr(3, 5);
    wr(0, (1 << B_EN) | (1 << B_M2M) | (1 << B_DIR) | (1 << B_MINC) | (1 << B_MSZ));
    repeat (80) @(negedge clk);
    chk(wr_idx == 5, "R13 all items under back-pressure", wr_idx, 5);
    ready_toggle = 1'b0; wr(0, 0); wr(4, 7);
  endtask

  task automatic t_zero;
    int b0;
    wr(3, 0); b0 = beat_idx;
    wr(0, (1 << B_EN) | (1 << B_M2M));
    repeat (20) @(negedge clk);
    chk(beat_idx == b0, "R8 zero count issues no beats", beat_idx - b0, 0);
    wr(0, 0);
  endtask

  task automatic finish;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_m2m();
    t_periph();
    t_circ();
    t_err();
    t_backpressure();
    t_zero();
    finish();
  end

endmodule